// File: doc/BRIEF.md
# LWE Ciphertext Row Accumulator

This block is the encryption datapath of a learning-with-errors scheme. It draws one selection bit per public-key row from a shared random-bit stream. It then takes the public-key rows one at a time and adds every row whose bit is set into a running equation. Four multiply-accumulate lanes split the row columns between them. The right-hand side of each selected row goes into a separate sum register.

When all rows have arrived, the block adds the message bit, scaled to floor(Q/2), to the sum. A decoder can then recover the bit with a Q/2 threshold. Each accumulated column and then the sum go one at a time to an external modulus unit over a request/grant handshake. The reduced words are collected into the ciphertext word.

The random bits and the rows come in on valid/ready streams, and the ciphertext leaves on one. A word moves only in a cycle where both valid and ready are high. The block lowers ready whenever it is in a phase that does not take that stream. A sender may hold valid high for as long as it likes. The output holds valid and data stable until the receiver raises ready.

Top module: `lwe_row_accum`

## Requirements
- R1: After reset, rnd_ready, row_ready, mod_req and ct_valid are all 0 until a start pulse is given.
- R2: After start, exactly M bits are taken from the random stream, one in each cycle where rnd_valid and rnd_ready are both high. The i-th bit taken is the coefficient of row i. rnd_ready is 0 outside this collection phase, and a cycle without rnd_valid consumes nothing.
- R3: row_ready is high only in the accumulation phase, which follows collection. Each row takes N/4 beats. In beat b, element k (row_data bits [k*W +: W]) is column 4b+k. row_sum is taken on the last beat of each row. rnd_ready and row_ready are never high together.
- R4: Each accumulated column j equals the sum, over all rows with coefficient 1, of that row's column j. Rows with coefficient 0 do not contribute.
- R5: The sum word is the sum of row_sum over the selected rows plus msg_bit times floor(Q/2). msg_bit is sampled with start. This total goes to the modulus unit like the columns do.
- R6: The words go to the modulus unit in order: column 0 to N-1, then the sum. mod_req stays high with mod_operand stable until mod_gnt. The reduced value mod_result is captured in the cycle where mod_gnt is high.
- R7: Ciphertext word j sits at ct_data bits [j*W +: W], and the reduced sum sits at bits [N*W +: W]. ct_valid rises only after the final reduced word. It stays high with ct_data stable until ct_ready, and then the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new ciphertext (taken when idle) |
| msg_bit | input | 1 | Plain-text bit, sampled with start |
| rnd_valid | input | 1 | Random bit present |
| rnd_bit | input | 1 | Random bit value |
| rnd_ready | output | 1 | Block takes a random bit |
| row_valid | input | 1 | Row beat present |
| row_ready | output | 1 | Block takes a row beat |
| row_data | input | 4*W | Four row elements of one beat |
| row_sum | input | W | Right-hand side of the row, used on its last beat |
| mod_req | output | 1 | Reduction request |
| mod_operand | output | AW | Value to reduce |
| mod_gnt | input | 1 | Reduction done, result valid |
| mod_result | input | W | Reduced value |
| ct_valid | output | 1 | Ciphertext ready |
| ct_ready | input | 1 | Receiver takes ciphertext |
| ct_data | output | (N+1)*W | Reduced columns and sum |

## Verification
A random bit or row beat is absorbed at the clock edge where valid and ready are both high. The bench drives each one at a falling edge and checks ready half a cycle later. It releases the word only after that rising edge. The phase change from collection to accumulation comes one cycle after the M-th bit, so the bench waits on ready instead of counting cycles. Each reduced word is stored at the edge that carries its grant, and ct_valid is high right after the edge of the last grant. The bench therefore polls ct_valid at falling edges and then reads every word. It then holds ct_ready low for several cycles to check that the output stays put.

// File: rtl/lwe_pkg.sv
package lwe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_COLLECT,
    PH_ACCUM,
    PH_REDUCE,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/lwe_coef_collector.sv
module lwe_coef_collector #(
  parameter int M  = 4,
  parameter int CW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         rnd_valid,
  input  logic         rnd_bit,
  output logic         rnd_ready,
  output logic [M-1:0] coef,
  output logic         full
);
  logic [CW-1:0] cnt;

  assign rnd_ready = en && (cnt < CW'(M));
  assign full      = (cnt == CW'(M));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt  <= '0;
      coef <= '0;
    end else if (rnd_ready && rnd_valid) begin
      for (int i = 0; i < M; i++)
        if (cnt == CW'(i)) coef[i] <= rnd_bit;
      cnt <= cnt + 1'b1;
    end
  end

  // R2: never more than M bits are taken
  a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(M));
  // R2: a cycle without rnd_valid consumes nothing
  a_r2_no_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rnd_valid && !clr) |=> $stable(cnt));
endmodule

// File: rtl/lwe_mac_lane.sv
module lwe_mac_lane #(
  parameter int W  = 12,
  parameter int AW = 16,
  parameter int D  = 2,
  parameter int BW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [BW-1:0]   beat,
  input  logic [W-1:0]    elem,
  output logic [D*AW-1:0] acc_flat
);
  logic [AW-1:0] acc [D];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int d = 0; d < D; d++) acc[d] <= '0;
    end else if (en) begin
      for (int d = 0; d < D; d++)
        if (beat == BW'(d)) acc[d] <= acc[d] + AW'(elem);
    end
  end

  for (genvar d = 0; d < D; d++) begin : g_out
    assign acc_flat[d*AW +: AW] = acc[d];
  end

  // R4: a selected nonzero element always moves the lane state
  a_r4_lane_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && elem != '0) |=> acc_flat != $past(acc_flat));
  // R4: an unselected beat leaves the lane untouched
  a_r4_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc_flat));
endmodule

// File: rtl/lwe_row_accum.sv
module lwe_row_accum
  import lwe_pkg::*;
#(
  parameter int N  = 8,
  parameter int M  = 4,
  parameter int W  = 12,
  parameter int Q  = 3329,
  parameter int AW = W + $clog2(M + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               msg_bit,
  input  logic               rnd_valid,
  input  logic               rnd_bit,
  output logic               rnd_ready,
  input  logic               row_valid,
  output logic               row_ready,
  input  logic [4*W-1:0]     row_data,
  input  logic [W-1:0]       row_sum,
  output logic               mod_req,
  output logic [AW-1:0]      mod_operand,
  input  logic               mod_gnt,
  input  logic [W-1:0]       mod_result,
  output logic               ct_valid,
  input  logic               ct_ready,
  output logic [(N+1)*W-1:0] ct_data
);
  localparam int LANES = 4;
  localparam int D     = N / LANES;
  localparam int BW    = (D > 1) ? $clog2(D) : 1;
  localparam int RW    = (M > 1) ? $clog2(M) : 1;
  localparam int CW    = $clog2(M + 1);
  localparam int IW    = $clog2(N + 1);
  localparam int HALF  = Q / 2;

  phase_t            ph;
  logic              msg_q;
  logic [BW-1:0]     bt;
  logic [RW-1:0]     rw;
  logic [IW-1:0]     widx;
  logic [AW-1:0]     sum_acc;
  logic [M-1:0]      coef;
  logic              coef_full, coef_cur, clr, row_acc, last_beat, last_row;
  logic [AW-1:0]     col_w [N];

  assign clr       = (ph == PH_IDLE) && start;
  assign row_ready = (ph == PH_ACCUM);
  assign row_acc   = row_ready && row_valid;
  assign last_beat = (bt == BW'(D - 1));
  assign last_row  = (rw == RW'(M - 1));
  assign coef_cur  = |(coef & (M'(1) << rw));
  assign mod_req   = (ph == PH_REDUCE);
  assign ct_valid  = (ph == PH_DONE);

  lwe_coef_collector #(.M(M), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(ph == PH_COLLECT),
    .rnd_valid(rnd_valid), .rnd_bit(rnd_bit), .rnd_ready(rnd_ready),
    .coef(coef), .full(coef_full)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [D*AW-1:0] acc_k;
    lwe_mac_lane #(.W(W), .AW(AW), .D(D), .BW(BW)) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(row_acc && coef_cur),
      .beat(bt), .elem(row_data[k*W +: W]), .acc_flat(acc_k)
    );
    for (genvar d = 0; d < D; d++) begin : g_col
      assign col_w[d*LANES + k] = acc_k[d*AW +: AW];
    end
  end

  always_comb begin
    mod_operand = sum_acc + (msg_q ? AW'(HALF) : '0);
    for (int j = 0; j < N; j++)
      if (widx == IW'(j)) mod_operand = col_w[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      msg_q   <= 1'b0;
      bt      <= '0;
      rw      <= '0;
      widx    <= '0;
      sum_acc <= '0;
      ct_data <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          msg_q   <= msg_bit;
          sum_acc <= '0;
          bt      <= '0;
          rw      <= '0;
          ph      <= PH_COLLECT;
        end
        PH_COLLECT: if (coef_full) ph <= PH_ACCUM;
        PH_ACCUM: if (row_valid) begin
          if (last_beat) begin
            bt <= '0;
            if (coef_cur) sum_acc <= sum_acc + AW'(row_sum);
            if (last_row) begin
              widx <= '0;
              ph   <= PH_REDUCE;
            end else begin
              rw <= rw + 1'b1;
            end
          end else begin
            bt <= bt + 1'b1;
          end
        end
        PH_REDUCE: if (mod_gnt) begin
          for (int j = 0; j <= N; j++)
            if (widx == IW'(j)) ct_data[j*W +: W] <= mod_result;
          if (widx == IW'(N)) ph <= PH_DONE;
          else widx <= widx + 1'b1;
        end
        PH_DONE: if (ct_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R3: the two input streams are never open together
  a_r3_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !(rnd_ready && row_ready));
  // R6: request held with stable operand until grant
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_req && !mod_gnt) |=> (mod_req && $stable(mod_operand)));
  // R7: output held until taken
  a_r7_ct_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_valid && !ct_ready) |=> (ct_valid && $stable(ct_data)));
  // R7: ciphertext appears only right after a grant
  a_r7_valid_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ct_valid) |-> $past(mod_gnt));
endmodule

// File: tb/tb_lwe_row_accum.sv
module tb_lwe_row_accum;
  localparam int N  = 8;
  localparam int M  = 4;
  localparam int W  = 12;
  localparam int Q  = 3329;
  localparam int AW = W + $clog2(M + 1) + 1;
  localparam int D  = N / 4;

  typedef struct packed {
    logic         msg;
    logic [M-1:0] coef;
    logic [7:0]   seed;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'b1011, 8'd3},
    '{1'b1, 4'b0110, 8'd17},
    '{1'b1, 4'b0000, 8'd5},
    '{1'b0, 4'b1111, 8'd200},
    '{1'b1, 4'b1111, 8'd255},
    '{1'b0, 4'b1000, 8'd9}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, msg_bit = 0, rnd_valid = 0, rnd_bit = 0, row_valid = 0;
  logic [4*W-1:0] row_data = '0;
  logic [W-1:0] row_sum = '0, mod_result = '0;
  logic mod_gnt = 0, ct_ready = 0;
  logic rnd_ready, row_ready, mod_req, ct_valid;
  logic [AW-1:0] mod_operand;
  logic [(N+1)*W-1:0] ct_data;

  int total = 0, bad = 0, cycles = 0, grants = 0, gap = 0, dly = 0;
  logic [AW-1:0] held_op;
  logic finished = 0;

  always #4 clk = ~clk;

  lwe_row_accum #(.N(N), .M(M), .W(W), .Q(Q)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_bit(msg_bit),
    .rnd_valid(rnd_valid), .rnd_bit(rnd_bit), .rnd_ready(rnd_ready),
    .row_valid(row_valid), .row_ready(row_ready), .row_data(row_data),
    .row_sum(row_sum), .mod_req(mod_req), .mod_operand(mod_operand),
    .mod_gnt(mod_gnt), .mod_result(mod_result), .ct_valid(ct_valid),
    .ct_ready(ct_ready), .ct_data(ct_data)
  );

  function automatic int elem(int r, int c, int s);
    return (s * 37 + r * 911 + c * 173 + r * c * 59) % Q;
  endfunction
  function automatic int rsum(int r, int s);
    return (s * 11 + r * 503) % Q;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Modulus unit model with a rotating 0..2 cycle grant delay
  always @(negedge clk) begin
    if (mod_req && !mod_gnt) begin
      if (dly == 0) held_op = mod_operand;
      else if (mod_operand != held_op) check("R6 operand stable", int'(mod_operand), int'(held_op));
      if (dly == gap) begin
        mod_gnt    = 1;
        mod_result = W'(int'(mod_operand) % Q);
        dly        = 0;
        gap        = (gap + 1) % 3;
        grants++;
      end else begin
        dly++;
      end
    end else begin
      mod_gnt = 0;
    end
  end

  task automatic push_bit(logic b);
    rnd_valid = 1; rnd_bit = b; #1;
    while (!rnd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rnd_valid = 0;
  endtask

  task automatic push_beat(int r, int b, int s);
    row_valid = 1;
    for (int k = 0; k < 4; k++) row_data[k*W +: W] = W'(elem(r, b*4 + k, s));
    row_sum = W'(rsum(r, s)); #1;
    while (!row_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    row_valid = 0;
  endtask

  task automatic run_vec(vec_t v);
    int exp_w [N+1];
    int tmo;
    logic [(N+1)*W-1:0] snap;
    for (int j = 0; j <= N; j++) exp_w[j] = 0;
    for (int r = 0; r < M; r++)
      if (v.coef[r]) begin
        for (int j = 0; j < N; j++) exp_w[j] += elem(r, j, int'(v.seed));
        exp_w[N] += rsum(r, int'(v.seed));
      end
    if (v.msg) exp_w[N] += Q / 2;
    grants = 0;
    @(negedge clk); start = 1; msg_bit = v.msg;
    @(negedge clk); start = 0; msg_bit = 0;
    row_valid = 1; #1;
    check("R3 row_ready low while collecting", int'(row_ready), 0);
    row_valid = 0;
    for (int i = 0; i < M; i++) begin
      if (i % 2 == 1) begin
        repeat (2) @(negedge clk);
        check("R2 stall keeps collecting", int'(rnd_ready), 1);
      end
      push_bit(v.coef[i]);
    end
    for (int r = 0; r < M; r++)
      for (int b = 0; b < D; b++) begin
        if (r == 0 && b == 0) begin
          rnd_valid = 1; #1;
          while (!row_ready) begin @(negedge clk); #1; end
          check("R2 rnd_ready low during rows", int'(rnd_ready), 0);
          rnd_valid = 0;
        end
        if ((r + b) % 3 == 2) @(negedge clk);
        push_beat(r, b, int'(v.seed));
      end
    tmo = 0;
    while (!ct_valid && tmo < 400) begin @(negedge clk); tmo++; end
    check("R7 ct_valid rises", int'(ct_valid), 1);
    for (int j = 0; j < N; j++)
      check("R4 column word", int'(ct_data[j*W +: W]), exp_w[j] % Q);
    check("R5 sum word with message", int'(ct_data[N*W +: W]), exp_w[N] % Q);
    check("R6 one grant per word", grants, N + 1);
    snap = ct_data;
    repeat (3) @(negedge clk);
    check("R7 valid held", int'(ct_valid), 1);
    check("R7 data held", int'(ct_data == snap), 1);
    ct_ready = 1;
    @(negedge clk);
    ct_ready = 0;
    check("R7 idle after take", int'(ct_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rnd_ready reset", int'(rnd_ready), 0);
    check("R1 row_ready reset", int'(row_ready), 0);
    check("R1 mod_req reset", int'(mod_req), 0);
    check("R1 ct_valid reset", int'(ct_valid), 0);
    rnd_valid = 1; row_valid = 1;
    repeat (3) @(negedge clk);
    check("R1 no stream taken before start", int'(rnd_ready | row_ready), 0);
    rnd_valid = 0; row_valid = 0;
    for (int v = 0; v < NV; v++) run_vec(VEC[v]);
    // directed: start pulse while idle again after back-to-back runs
    run_vec('{1'b1, 4'b0001, 8'd0});
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule